// File: doc/BRIEF.md
# Register File with Indirect Addressing

This block is the byte-wide data memory of a small 8-bit controller core. A 7-bit address space of 128 locations is split into a low half and a high half. The high half (40h to 7Fh) is 64 bytes of general-purpose storage. The low half holds a window of special registers at fixed addresses. In this block those registers are plain bytes of storage. Every other low-half address is unassigned: it reads as zero and drops writes.

Address 00h has no storage of its own. It is a virtual port. Any read, write or bit operation on it is sent to the location named by a 7-bit memory pointer, which lives at 01h. When the pointer itself holds 00h, that access reads zero and changes nothing. Read data is combinational from the address. Byte writes take effect at the rising clock edge. Single-bit set and clear operations also take effect at the rising clock edge, as a read-modify-write of the addressed byte within one cycle.

Top module: `rfile_indirect`

## Requirements
- R1: After reset every stored byte is 00h, so every address reads 00h except 01h, which reads 80h.
- R2: A byte written to any address from 40h to 7Fh reads back unchanged at that address from the next cycle on.
- R3: The special-register addresses 05h-0Bh, 0Dh, 0Eh, 12h-15h, 18h, 19h and 21h-23h each store a written byte and read it back.
- R4: Every other address from 02h to 3Fh reads 00h. A write to such an address changes no location.
- R5: The pointer at 01h stores only bits 6:0 of a write. Bit 7 of a read of 01h is always 1.
- R6: A read of address 00h returns the location that the pointer selects. A write to 00h is stored at that location, and this holds for every region, including the pointer itself.
- R7: While the pointer holds 00h, a read of address 00h returns 00h. A write or bit operation on 00h changes no location.
- R8: With bit_op_en=1 and wr_en=0, the bit at position bit_idx (0 is the LSB) of the addressed byte becomes bit_set (1 sets the bit, 0 clears it). All other bits of that byte are kept.
- R9: A bit operation on address 00h acts on the byte that the pointer selects.
- R10: When wr_en and bit_op_en are both 1, the full byte wr_data is stored and the bit operation is ignored.
- R11: rd_data follows addr within the same cycle. During a write cycle it still shows the old contents of the addressed location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all storage updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (7) | Direct address; 00h selects the indirect port |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | DATA_W (8) | Byte to write |
| bit_op_en | input | 1 | Single-bit operation strobe |
| bit_set | input | 1 | Bit operation value: 1 sets, 0 clears |
| bit_idx | input | clog2(DATA_W) (3) | Bit position for the bit operation |
| rd_data | output | DATA_W (8) | Combinational read of the effective location |

## Verification
The hardest case to reach is an access that loops back on the pointer. This happens when address 00h is used while the pointer holds 00h, or while it holds 01h so that the pointer redirects onto itself. Neither case can be set up directly. The pointer must first be loaded through 01h, and only then is the virtual port used for a read, a byte write and a bit operation. After each step the pointer, the 00h port and the whole general-purpose area are read back to show what did or did not change. The same approach drives bit operations through the indirect port onto general bytes. A read of the location in the same cycle as each write also confirms that the old value is still shown.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_PTR  = 2'd1,
      RGN_SFR  = 2'd2,
      RGN_GP   = 2'd3
   } rfi_region_e;
endpackage

// File: rtl/rfi_addr_resolve.sv
module rfi_addr_resolve
   import rfi_pkg::*;
#(
   parameter int ADDR_W   = 7,
   parameter int IND_ADDR = 0,
   parameter int PTR_ADDR = 1,
   parameter logic [(1<<(ADDR_W-1))-1:0] SPECIAL_MAP = '0
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-2:0] eff_lo,
   output logic              null_acc,
   output rfi_region_e       region
);
   localparam int LO_W = ADDR_W - 1;

   logic              indirect;
   logic [ADDR_W-1:0] eff;

   always_comb begin
      indirect = (addr == ADDR_W'(IND_ADDR));
      eff      = indirect ? ptr : addr;
      null_acc = indirect && (ptr == ADDR_W'(IND_ADDR));
      eff_lo   = eff[LO_W-1:0];
      if (null_acc)
         region = RGN_NONE;
      else if (eff[ADDR_W-1])
         region = RGN_GP;
      else if (eff == ADDR_W'(PTR_ADDR))
         region = RGN_PTR;
      else if (SPECIAL_MAP[eff[LO_W-1:0]])
         region = RGN_SFR;
      else
         region = RGN_NONE;
   end
endmodule

// File: rtl/rfi_gp_bank.sv
module rfi_gp_bank #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-2:0] idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int ROWS = 1 << (ADDR_W - 1);

   logic [DATA_W-1:0] rows [ROWS];

   for (genvar i = 0; i < ROWS; i++) begin : g_row
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (idx == (ADDR_W-1)'(i)))
            q <= wr_data;
      end
      assign rows[i] = q;
   end

   assign rd_data = rows[idx];
endmodule

// File: rtl/rfi_sfr_bank.sv
module rfi_sfr_bank #(
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 8,
   parameter int IND_ADDR = 0,
   parameter int PTR_ADDR = 1,
   parameter logic [(1<<(ADDR_W-1))-1:0] SPECIAL_MAP = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-2:0] idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int ROWS = 1 << (ADDR_W - 1);

   logic [DATA_W-1:0] rows [ROWS];

   for (genvar i = 0; i < ROWS; i++) begin : g_row
      if (SPECIAL_MAP[i] && (i != PTR_ADDR) && (i != IND_ADDR)) begin : g_store
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && (idx == (ADDR_W-1)'(i)))
               q <= wr_data;
         end
         assign rows[i] = q;
      end else begin : g_hole
         assign rows[i] = '0;
      end
   end

   assign rd_data = rows[idx];
endmodule

// File: rtl/rfi_bit_merge.sv
module rfi_bit_merge #(
   parameter int DATA_W = 8
)(
   input  logic [DATA_W-1:0]         cur,
   input  logic [$clog2(DATA_W)-1:0] bit_idx,
   input  logic                      bit_set,
   output logic [DATA_W-1:0]         merged
);
   always_comb begin
      merged          = cur;
      merged[bit_idx] = bit_set;
   end
endmodule

// File: rtl/rfile_indirect.sv
module rfile_indirect
   import rfi_pkg::*;
#(
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 8,
   parameter int IND_ADDR = 0,
   parameter int PTR_ADDR = 1,
   parameter logic [(1<<(ADDR_W-1))-1:0] SPECIAL_MAP = 64'h0000_000E_033C_6FE2
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      wr_en,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic                      bit_op_en,
   input  logic                      bit_set,
   input  logic [$clog2(DATA_W)-1:0] bit_idx,
   output logic [DATA_W-1:0]         rd_data
);
   localparam int LO_W  = ADDR_W - 1;
   localparam int PAD_W = DATA_W - ADDR_W;

   // elaboration-time parameter checks
   if (DATA_W <= ADDR_W) begin : g_bad_width
      $error("rfile_indirect: DATA_W must exceed ADDR_W");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("rfile_indirect: ADDR_W too small");
   end
   if (IND_ADDR == PTR_ADDR) begin : g_bad_ptr
      $error("rfile_indirect: pointer and indirect port share an address");
   end
   if (IND_ADDR >= (1 << LO_W) || PTR_ADDR >= (1 << LO_W)) begin : g_bad_low
      $error("rfile_indirect: pointer and indirect port must sit in the low half");
   end

   logic [ADDR_W-1:0] ptr_q;
   logic [LO_W-1:0]   eff_lo;
   logic              null_acc;
   rfi_region_e       region;
   logic [DATA_W-1:0] gp_rd, sfr_rd, cur_rd, merged, wbyte, ptr_view;
   logic              commit;

   rfi_addr_resolve #(
      .ADDR_W(ADDR_W), .IND_ADDR(IND_ADDR), .PTR_ADDR(PTR_ADDR),
      .SPECIAL_MAP(SPECIAL_MAP)
   ) u_resolve (
      .addr(addr), .ptr(ptr_q), .eff_lo(eff_lo),
      .null_acc(null_acc), .region(region)
   );

   assign commit = (wr_en | bit_op_en) & ~null_acc;
   assign wbyte  = wr_en ? wr_data : merged;

   rfi_gp_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gp (
      .clk(clk), .rst_n(rst_n),
      .wr_en(commit && (region == RGN_GP)),
      .idx(eff_lo), .wr_data(wbyte), .rd_data(gp_rd)
   );

   rfi_sfr_bank #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IND_ADDR(IND_ADDR),
      .PTR_ADDR(PTR_ADDR), .SPECIAL_MAP(SPECIAL_MAP)
   ) u_sfr (
      .clk(clk), .rst_n(rst_n),
      .wr_en(commit && (region == RGN_SFR)),
      .idx(eff_lo), .wr_data(wbyte), .rd_data(sfr_rd)
   );

   // pointer: only the low ADDR_W bits are stored, the rest read as ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (commit && (region == RGN_PTR))
         ptr_q <= wbyte[ADDR_W-1:0];
   end

   assign ptr_view = {{PAD_W{1'b1}}, ptr_q};

   always_comb begin
      unique case (region)
         RGN_GP:  cur_rd = gp_rd;
         RGN_SFR: cur_rd = sfr_rd;
         RGN_PTR: cur_rd = ptr_view;
         default: cur_rd = '0;
      endcase
   end

   rfi_bit_merge #(.DATA_W(DATA_W)) u_merge (
      .cur(cur_rd), .bit_idx(bit_idx), .bit_set(bit_set), .merged(merged)
   );

   assign rd_data = cur_rd;
endmodule

// File: rtl/rfi_checker.sv
module rfi_checker #(
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 8,
   parameter int IND_ADDR = 0,
   parameter int PTR_ADDR = 1,
   parameter logic [(1<<(ADDR_W-1))-1:0] SPECIAL_MAP = '0
)(
   input logic                      clk,
   input logic                      rst_n,
   input logic [ADDR_W-1:0]         addr,
   input logic                      wr_en,
   input logic [DATA_W-1:0]         wr_data,
   input logic                      bit_op_en,
   input logic                      bit_set,
   input logic [$clog2(DATA_W)-1:0] bit_idx,
   input logic [DATA_W-1:0]         rd_data,
   input logic [ADDR_W-1:0]         ptr_q
);
   localparam int LO_W = ADDR_W - 1;

   AST_PTR_TOP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(PTR_ADDR)) |-> (&rd_data[DATA_W-1:ADDR_W])); // R5

   AST_PTR_LOW_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && ($past(addr) == ADDR_W'(PTR_ADDR)) && (addr == ADDR_W'(PTR_ADDR)))
      |-> (rd_data[ADDR_W-1:0] == $past(wr_data[ADDR_W-1:0]))); // R5

   AST_NULL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((addr == ADDR_W'(IND_ADDR)) && (ptr_q == ADDR_W'(IND_ADDR))) |-> (rd_data == '0)); // R7

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr[ADDR_W-1] && (addr != ADDR_W'(IND_ADDR)) && (addr != ADDR_W'(PTR_ADDR))
       && !SPECIAL_MAP[addr[LO_W-1:0]]) |-> (rd_data == '0)); // R4

   AST_GP_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && $past(addr[ADDR_W-1]) && (addr == $past(addr)))
      |-> (rd_data == $past(wr_data))); // R2

   AST_BIT_OP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bit_op_en && !wr_en) && $past(addr[ADDR_W-1]) && (addr == $past(addr)))
      |-> (rd_data[$past(bit_idx)] == $past(bit_set))); // R8
endmodule

bind rfile_indirect rfi_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IND_ADDR(IND_ADDR),
   .PTR_ADDR(PTR_ADDR), .SPECIAL_MAP(SPECIAL_MAP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
   .bit_op_en(bit_op_en), .bit_set(bit_set), .bit_idx(bit_idx),
   .rd_data(rd_data), .ptr_q(ptr_q)
);

// File: tb/sim_rfile_indirect.sv
`timescale 1ns/1ps
module sim_rfile_indirect;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       bit_op_en = 1'b0;
   logic       bit_set = 1'b0;
   logic [2:0] bit_idx = '0;
   logic [7:0] rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] q_exp [$];
   logic [6:0] q_addr [$];
   string      q_tag [$];

   logic [7:0] m [128];

   always #2.5 clk = ~clk;

   rfile_indirect u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .bit_op_en(bit_op_en), .bit_set(bit_set), .bit_idx(bit_idx), .rd_data(rd_data)
   );

   function automatic bit is_sfr(input logic [6:0] a);
      case (a)
         7'h05, 7'h06, 7'h07, 7'h08, 7'h09, 7'h0A, 7'h0B, 7'h0D, 7'h0E,
         7'h12, 7'h13, 7'h14, 7'h15, 7'h18, 7'h19, 7'h21, 7'h22, 7'h23: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] model_read(input logic [6:0] a);
      logic [6:0] ea;
      ea = (a == 7'h00) ? m[1][6:0] : a;
      if (ea == 7'h00) return 8'h00;
      if (ea == 7'h01) return {1'b1, m[1][6:0]};
      if (ea[6] || is_sfr(ea)) return m[ea];
      return 8'h00;
   endfunction

   function automatic void model_apply(input logic [6:0] a, input logic we,
                                       input logic [7:0] wd, input logic bop,
                                       input logic bs, input logic [2:0] bi);
      logic [6:0] ea;
      logic [7:0] nv;
      ea = (a == 7'h00) ? m[1][6:0] : a;
      if (ea == 7'h00 || (!we && !bop)) return;
      nv = model_read(a);
      if (we) nv = wd;
      else nv[bi] = bs;
      if (ea == 7'h01) m[1] = {1'b0, nv[6:0]};
      else if (ea[6] || is_sfr(ea)) m[ea] = nv;
   endfunction

   // driver: one cycle of stimulus, expected read value pushed to the scoreboard
   task automatic cyc(input logic [6:0] a, input logic we, input logic [7:0] wd,
                      input logic bop, input logic bs, input logic [2:0] bi,
                      input string tag);
      @(negedge clk);
      addr = a; wr_en = we; wr_data = wd; bit_op_en = bop; bit_set = bs; bit_idx = bi;
      q_exp.push_back(model_read(a));
      q_addr.push_back(a);
      q_tag.push_back(tag);
      model_apply(a, we, wd, bop, bs, bi);
   endtask

   task automatic rd(input logic [6:0] a, input string tag);
      cyc(a, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0, tag);
   endtask

   task automatic wr(input logic [6:0] a, input logic [7:0] d);
      cyc(a, 1'b1, d, 1'b0, 1'b0, 3'd0, "R11");
   endtask

   task automatic bop(input logic [6:0] a, input logic s, input logic [2:0] i);
      cyc(a, 1'b0, 8'h00, 1'b1, s, i, "R11");
   endtask

   // monitor: pops expected items and compares with the port
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q_exp.size() > 0) begin
            logic [7:0] e;
            logic [6:0] a;
            string t;
            e = q_exp.pop_front();
            a = q_addr.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (rd_data !== e) begin
               fails++;
               $display("FAIL %s addr=%h actual=%h expected=%h", t, a, rd_data, e);
            end
         end
      end
   end

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 128; i++) m[i] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents (also covers reserved and null reads)
      for (int a = 0; a < 128; a++) rd(7'(a), "R1");

      // R2: general-purpose area
      for (int a = 64; a < 128; a++) wr(7'(a), 8'(a * 3) ^ 8'hA5);
      for (int a = 64; a < 128; a++) rd(7'(a), "R2");

      // R3: special registers
      for (int a = 2; a < 64; a++) if (is_sfr(7'(a))) wr(7'(a), 8'(a * 7 + 1));
      for (int a = 2; a < 64; a++) if (is_sfr(7'(a))) rd(7'(a), "R3");

      // R4: reserved addresses ignore writes and read zero
      for (int a = 2; a < 64; a++) if (!is_sfr(7'(a))) wr(7'(a), 8'hFF);
      for (int a = 2; a < 64; a++) rd(7'(a), "R4");
      for (int a = 64; a < 128; a += 9) rd(7'(a), "R4");

      // R5: pointer width and forced top bit
      wr(7'h01, 8'hFF); rd(7'h01, "R5");
      wr(7'h01, 8'h45); rd(7'h01, "R5");

      // R6: indirect port
      wr(7'h01, 8'h50); wr(7'h00, 8'h33); rd(7'h50, "R6"); rd(7'h00, "R6");
      wr(7'h01, 8'h05); wr(7'h00, 8'h9C); rd(7'h05, "R6"); rd(7'h00, "R6");
      wr(7'h01, 8'h03); wr(7'h00, 8'h5E); rd(7'h00, "R6"); rd(7'h03, "R6");
      wr(7'h01, 8'h01); rd(7'h00, "R6");
      wr(7'h00, 8'h42); rd(7'h01, "R6"); rd(7'h42, "R6");

      // R7: pointer holding zero
      wr(7'h01, 8'h00); rd(7'h00, "R7");
      wr(7'h00, 8'h77);
      bop(7'h00, 1'b1, 3'd3);
      rd(7'h01, "R7"); rd(7'h00, "R7");
      for (int a = 64; a < 128; a++) rd(7'(a), "R7");

      // R8: direct bit operations
      wr(7'h60, 8'h00);
      for (int b = 0; b < 8; b++) begin bop(7'h60, 1'b1, 3'(b)); rd(7'h60, "R8"); end
      for (int b = 0; b < 8; b += 2) begin bop(7'h60, 1'b0, 3'(b)); rd(7'h60, "R8"); end
      bop(7'h0A, 1'b1, 3'd7); rd(7'h0A, "R8");
      bop(7'h0A, 1'b0, 3'd0); rd(7'h0A, "R8");
      wr(7'h01, 8'h2A);
      bop(7'h01, 1'b0, 3'd7); rd(7'h01, "R8");
      bop(7'h01, 1'b1, 3'd0); rd(7'h01, "R8");
      bop(7'h25, 1'b1, 3'd4); rd(7'h25, "R8");

      // R9: bit operations through the indirect port
      wr(7'h01, 8'h61); wr(7'h61, 8'hF0);
      bop(7'h00, 1'b1, 3'd2); rd(7'h61, "R9");
      bop(7'h00, 1'b0, 3'd7); rd(7'h00, "R9"); rd(7'h61, "R9");

      // R10: byte write wins over a simultaneous bit operation
      cyc(7'h62, 1'b1, 8'h3C, 1'b1, 1'b1, 3'd0, "R11"); rd(7'h62, "R10");
      cyc(7'h62, 1'b1, 8'h81, 1'b1, 1'b0, 3'd0, "R11"); rd(7'h62, "R10");

      // R11: same-cycle read shows the old value during a write
      wr(7'h63, 8'h11);
      cyc(7'h63, 1'b1, 8'h22, 1'b0, 1'b0, 3'd0, "R11");
      rd(7'h63, "R11");

      @(negedge clk);
      wr_en = 1'b0; bit_op_en = 1'b0;
      repeat (2) @(negedge clk);
      #2;
      done = 1'b1;
      summary();
      $finish;
   end
endmodule